// File: doc/BRIEF.md
# Saturating Retired-Instruction Counter

This block keeps the count of instructions that a coprocessor has completed without error during its current or most recent operation. A start pulse together with an operation kind opens each operation. Only an operation of the execute kind lets retire strobes advance the count, and the count stops at its all-ones value instead of wrapping. The host reads the count through a registered output.

The count is forced to read as zero while the coprocessor is locked after a fatal fault. The stored value is kept underneath and shows again when the lock drops. The host may clear the count by writing to it, but only while the coprocessor is not busy. A write made while busy is dropped. After an operation ends, the count keeps its final value until the next start or a host clear.

Top module: `retire_count_unit`

## Requirements
- R1: A synchronous active-high reset drives count_o to zero at the next clock edge and holds it there while reset stays high.
- R2: A cycle with op_start_i high sets the count to zero at that edge, even if the count was nonzero. A retire strobe in the same cycle is not counted.
- R3: The operation kind is sampled with the start pulse, encoded 0 = execute, 1 = data wipe, 2 = instruction wipe, 3 = internal wipe. After a start of kind 1, 2 or 3, retire strobes leave the count at zero.
- R4: A retire strobe with retire_err_i high leaves the count unchanged.
- R5: The count stops at 2^CNT_W-1 (default 32 bits), and further error-free retires leave it there.
- R6: After an edge at which locked_i was high, count_o reads zero. Once locked_i is low again, count_o shows the retained count.
- R7: host_clr_i with busy_i low clears the count at that edge. With busy_i high, host_clr_i has no effect.
- R8: When host_clr_i with busy_i low and a retire strobe arrive in the same cycle, the clear wins and the count is zero.
- R9: When busy_i falls at the end of an operation, the count keeps its value until the next start or host clear.
- R10: Each error-free retire strobe during an execute operation adds exactly one, and the result is visible on count_o right after the edge that sampled the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_start_i | input | 1 | One-cycle pulse that opens a new operation |
| op_kind_i | input | 2 | Operation kind sampled with the start pulse (0 = execute, 1 to 3 = wipes) |
| retire_i | input | 1 | One instruction retired this cycle |
| retire_err_i | input | 1 | The retiring instruction raised an error |
| locked_i | input | 1 | Coprocessor locked after a fatal fault |
| host_clr_i | input | 1 | Host write strobe to the count (any value clears) |
| busy_i | input | 1 | Coprocessor is running an operation |
| count_o | output | CNT_W | Count seen by the host |

## Verification
The counting path is driven with plain retire runs, retires that carry the error flag, retires during each wipe kind, and retires that coincide with a start pulse. These patterns separate a correct kind gate and error gate from a counter that simply counts every strobe. Host clears are applied while busy and while idle, and once together with a retire, which shows the idle gating and the priority of the clear. A narrow second instance is driven past its all-ones value to tell saturation from wrap-around. A lock and unlock around a nonzero count shows that the masking sits at the output and does not destroy the stored count.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  typedef enum logic [1:0] {
    OP_EXEC   = 2'd0,
    OP_WIPE_D = 2'd1,
    OP_WIPE_I = 2'd2,
    OP_WIPE_S = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic zero;
    logic step;
  } cnt_cmd_t;

endpackage

// File: rtl/rcu_ctrl.sv
module rcu_ctrl
  import rcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_start_i,
  input  logic [1:0] op_kind_i,
  input  logic       retire_i,
  input  logic       retire_err_i,
  input  logic       host_clr_i,
  input  logic       busy_i,
  output cnt_cmd_t   cmd_o
);

  op_kind_e kind_in;
  logic     exec_q;
  logic     host_zero;
  logic     zero_now;

  assign kind_in = op_kind_e'(op_kind_i);

  // Operation kind is captured once per start and held for the operation
  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q <= 1'b0;
    end else if (op_start_i) begin
      exec_q <= (kind_in == OP_EXEC);
    end
  end

  // A host write only takes effect while the coprocessor is idle
  assign host_zero = host_clr_i & ~busy_i;
  assign zero_now  = op_start_i | host_zero;

  always_comb begin
    cmd_o.zero = zero_now;
    cmd_o.step = retire_i & ~retire_err_i & exec_q & ~zero_now;
  end

endmodule

// File: rtl/rcu_sat_cnt.sv
module rcu_sat_cnt
  import rcu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_cmd_t         cmd_i,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic [CNT_W-1:0] cnt_q_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;

  assign at_max = (cnt_q == CntMax);

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_i.zero) begin
      cnt_d = '0;
    end else if (cmd_i.step && !at_max) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_d_o = cnt_d;
  assign cnt_q_o = cnt_q;

endmodule

// File: rtl/rcu_out_reg.sv
module rcu_out_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             locked_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] out_q;

  // Registered view for the host; masked to zero while locked
  always_ff @(posedge clk) begin
    if (rst || locked_i) begin
      out_q <= '0;
    end else begin
      out_q <= cnt_d_i;
    end
  end

  assign count_o = out_q;

endmodule

// File: rtl/retire_count_unit.sv
module retire_count_unit
  import rcu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_start_i,
  input  logic [1:0]       op_kind_i,
  input  logic             retire_i,
  input  logic             retire_err_i,
  input  logic             locked_i,
  input  logic             host_clr_i,
  input  logic             busy_i,
  output logic [CNT_W-1:0] count_o
);

  cnt_cmd_t         cmd;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  rcu_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .op_start_i   (op_start_i),
    .op_kind_i    (op_kind_i),
    .retire_i     (retire_i),
    .retire_err_i (retire_err_i),
    .host_clr_i   (host_clr_i),
    .busy_i       (busy_i),
    .cmd_o        (cmd)
  );

  rcu_sat_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cmd_i   (cmd),
    .cnt_d_o (cnt_d),
    .cnt_q_o (cnt_q)
  );

  rcu_out_reg #(
    .CNT_W (CNT_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .locked_i (locked_i),
    .cnt_d_i  (cnt_d),
    .count_o  (count_o)
  );

endmodule

// File: rtl/retire_count_chk.sv
module retire_count_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             op_start_i,
  input logic [1:0]       op_kind_i,
  input logic             retire_i,
  input logic             retire_err_i,
  input logic             locked_i,
  input logic             host_clr_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic idle_clr;
  assign idle_clr = host_clr_i & ~busy_i;

  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    op_start_i |=> (cnt_q == '0));

  p_wipe_stays_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (op_start_i && op_kind_i != 2'd0) |=> (cnt_q == '0));

  p_err_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    (retire_err_i && !op_start_i && !idle_clr) |=> $stable(cnt_q));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CntMax && !op_start_i && !idle_clr) |=> (cnt_q == CntMax));

  p_locked_zero_r6: assert property (@(posedge clk) disable iff (rst)
    locked_i |=> (count_o == '0));

  p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
    idle_clr |=> (cnt_q == '0));

  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (host_clr_i && busy_i && !op_start_i && !retire_i) |=> $stable(cnt_q));

  p_single_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!op_start_i && !idle_clr) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  p_unlocked_view_r6: assert property (@(posedge clk) disable iff (rst)
    !locked_i |=> (count_o == cnt_q));

endmodule

bind retire_count_unit retire_count_chk #(
  .CNT_W (CNT_W)
) u_retire_count_chk (
  .clk          (clk),
  .rst          (rst),
  .op_start_i   (op_start_i),
  .op_kind_i    (op_kind_i),
  .retire_i     (retire_i),
  .retire_err_i (retire_err_i),
  .locked_i     (locked_i),
  .host_clr_i   (host_clr_i),
  .busy_i       (busy_i),
  .cnt_q        (cnt_q),
  .count_o      (count_o)
);

// File: tb/test_retire_count_unit.sv
module test_retire_count_unit;

  localparam int W     = 32;
  localparam int NW    = 4;
  localparam int NVEC  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_start_i = 1'b0;
  logic [1:0]    op_kind_i = 2'd0;
  logic          retire_i = 1'b0;
  logic          retire_err_i = 1'b0;
  logic          locked_i = 1'b0;
  logic          host_clr_i = 1'b0;
  logic          busy_i = 1'b0;
  logic [W-1:0]  count_o;
  logic [NW-1:0] count_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  retire_count_unit #(.CNT_W(W)) i_retire_count_unit (
    .clk(clk), .rst(rst), .op_start_i(op_start_i), .op_kind_i(op_kind_i),
    .retire_i(retire_i), .retire_err_i(retire_err_i), .locked_i(locked_i),
    .host_clr_i(host_clr_i), .busy_i(busy_i), .count_o(count_o)
  );

  retire_count_unit #(.CNT_W(NW)) i_retire_count_unit_sat (
    .clk(clk), .rst(rst), .op_start_i(op_start_i), .op_kind_i(op_kind_i),
    .retire_i(retire_i), .retire_err_i(retire_err_i), .locked_i(locked_i),
    .host_clr_i(host_clr_i), .busy_i(busy_i), .count_o(count_n)
  );

  // {start, kind[1:0], retire, err, lock, clr, busy, expected[2:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R2 start execute
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R10
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R10
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2}, // R4 error retire
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // R10
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3}, // R7 busy write ignored
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // hold
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3}, // R9 end of operation
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R6 locked
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3}, // R6 unlocked
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R8 clear beats retire
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R3 data wipe
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R3
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R3
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R2 retire with start
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R10
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R10
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R2 clears nonzero
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R3 internal wipe
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}  // R7 idle clear
  };

  localparam string VREQ [NVEC] = '{
    "R2", "R10", "R10", "R4", "R10", "R7", "R9", "R9", "R6", "R6",
    "R8", "R3", "R3", "R3", "R2", "R10", "R10", "R2", "R3", "R7"
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs set at the falling edge; result sampled at the next falling edge
  task automatic cycle(input logic st, input logic [1:0] kd, input logic rt,
                       input logic er, input logic lk, input logic cl,
                       input logic bz);
    op_start_i   = st;
    op_kind_i    = kd;
    retire_i     = rt;
    retire_err_i = er;
    locked_i     = lk;
    host_clr_i   = cl;
    busy_i       = bz;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R1", count_o, '0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][10], VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5],
            VEC[i][4], VEC[i][3]);
      check(VREQ[i], count_o, {29'd0, VEC[i][2:0]});
    end

    // R5: the narrow instance stops at 15 while the wide one keeps counting
    cycle(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 18; k++) begin
      cycle(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    end
    check("R5", {28'd0, count_n}, 32'd15);
    check("R10", count_o, 32'd18);
    cycle(1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R4", count_o, 32'd18);
    check("R5", {28'd0, count_n}, 32'd15);
    cycle(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7", count_o, 32'd18);
    cycle(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5", {28'd0, count_n}, 32'd0);
    check("R2", count_o, 32'd0);
    cycle(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3", count_o, 32'd0);

    // R1: reset in the middle of a counting run
    cycle(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      cycle(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    end
    check("R10", count_o, 32'd5);
    rst = 1'b1;
    cycle(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R1", count_o, 32'd0);
    rst = 1'b0;
    cycle(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3", count_o, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule